// File: doc/BRIEF.md
# Bus Arbiter with Stalled-Master Lockout

This block is the central arbiter for a shared, PCI-style parallel bus. Each master has a request line and a grant line. Exactly one grant is active at any time. When no eligible master is asking for the bus, the grant rests on a default agent chosen by parameter. The arbiter watches the shared, active-low FRAME and IRDY lines. From them it tells when the bus is idle and when the master that holds the grant has opened a transaction. Requesters are served in a rotating order, so the grant moves on each time its holder starts a transaction.

An optional watchdog protects the bus from a master that asks for it and then never uses it. The watchdog is enabled when the lockout-disable bit of the arbitration control word is 0. That bit is bit 12 of the word, and the integrator wires it to `lockoutOff`. With the watchdog enabled, a requesting grant holder that leaves the bus idle for too long loses its grant and is marked as locked out. The arbiter then ignores that master until it drops its request for at least one clock. With the watchdog disabled, a grant holder keeps the grant until it starts a transaction or withdraws its request.

Request and grant vectors on the ports are active-high, one bit per master. The bus lines are sampled on the rising clock edge.

Top module: `lockout_arbiter`

## Requirements
- R1: While `rstN` is low, and after it is released, `gnt` equals the one-hot mask of the park agent `PARK` (default 0) and `lockedOut` is all zero.
- R2: `gnt` has exactly one bit set in every cycle after reset.
- R3: At any rising edge with no eligible request, `gnt` becomes the park mask. At any rising edge where the holder has no live request and some master has an eligible request, the grant goes to that master. The new grant is visible after that edge.
- R4: A transaction start is an edge where `frameN` is sampled low after being sampled high. At a transaction start, the grant passes to the first eligible requester found by counting upward from the holder's index and wrapping at N. If no other master is eligible, the holder keeps the grant.
- R5: If the holder's request is sampled low, the arbiter re-arbitrates at that same edge.
- R6: The bus counts as idle only when `frameN` and `irdyN` are both sampled high. An edge on which either line is low restarts the idle count.
- R7: With `lockoutOff`=0, the watchdog acts at the 16th consecutive idle edge (LIMIT=16) after the grant was given or the count last restarted, if the holder is still requesting and has not started. At that edge the holder loses its grant and its `lockedOut` bit is set. A FRAME assertion sampled at that 16th edge counts as a start in time.
- R8: While a master's `lockedOut` bit is set, its request is ignored. The bit clears at the first edge where that master's request is sampled low. From then on the master is eligible again.
- R9: With `lockoutOff`=1, no lockout occurs. A requesting holder keeps its grant on an idle bus for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lockoutOff | input | 1 | Lockout-disable bit of the arbitration control word (bit 12); 0 enables the watchdog |
| frameN | input | 1 | Shared FRAME line, active low |
| irdyN | input | 1 | Shared IRDY line, active low |
| req | input | N | Per-master request, active high |
| gnt | output | N | Per-master grant, one-hot, active high |
| lockedOut | output | N | Per-master lockout flag |

## Verification
Every result is registered once. A request, a bus-line change or a watchdog expiry is therefore visible on `gnt` and `lockedOut` right after the rising edge that samples it. The bench drives inputs on the falling edge and queues the expected values for the next rising edge. A monitor compares them a quarter period after that edge. The watchdog cases count idle edges from the edge that gave the grant. The bench checks that the grant is still held after the 15th idle edge and gone after the 16th. Each lockout release is checked on the single edge where the request is first seen low.

// File: rtl/lockArbPkg.sv
package lockArbPkg;
  // Strobes from the control side to the grant datapath
  typedef struct packed {
    logic rearb;      // choose a new grant holder at this edge
    logic lockOwner;  // watchdog expired: lock out the current holder
  } arbStrobeT;
endpackage

// File: rtl/arbControl.sv
module arbControl
  import lockArbPkg::*;
#(
  parameter int LIMIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lockEnable,
  input  logic      frameN,
  input  logic      irdyN,
  input  logic      ownerReq,
  output arbStrobeT strobe
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic             frameNq;
  logic             busIdle;
  logic             startEdge;
  logic             timeout;
  logic [CNT_W-1:0] idleCnt;

  assign busIdle   = frameN & irdyN;
  assign startEdge = ~frameN & frameNq;
  assign timeout   = lockEnable & ownerReq & busIdle & (idleCnt == LAST);

  always_comb begin
    strobe.rearb     = ~ownerReq | startEdge | timeout;
    strobe.lockOwner = timeout;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameNq <= 1'b1;
      idleCnt <= '0;
    end else begin
      frameNq <= frameN;
      if (strobe.rearb || !busIdle || !lockEnable)
        idleCnt <= '0;
      else
        idleCnt <= idleCnt + 1'b1;
    end
  end

  // R6: the idle count never passes the limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt < CNT_W'(LIMIT));

  // R6: a busy edge restarts the idle count
  a_r6_busy_clears: assert property (@(posedge clk) disable iff (!rstN)
    !busIdle |=> idleCnt == '0);

  // R7: the watchdog only fires while the bus is idle
  a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockOwner |-> (frameN && irdyN));

  // R9: with the feature off no lockout is raised
  a_r9_no_timeout_off: assert property (@(posedge clk) disable iff (!rstN)
    !lockEnable |-> !strobe.lockOwner);
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import lockArbPkg::*;
#(
  parameter int N    = 4,
  parameter int PARK = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  input  arbStrobeT    strobe,
  output logic [N-1:0] gnt,
  output logic [N-1:0] lockedOut,
  output logic         ownerReq
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [N-1:0] PARK_MASK = N'(1) << PARK;

  logic [IDX_W-1:0] ownerIdx;
  logic [N-1:0]     eligible;
  logic [N-1:0]     nextGnt;

  assign ownerReq = |(gnt & req & ~lockedOut);
  assign eligible = req & ~lockedOut & ~(strobe.lockOwner ? gnt : '0);

  // index of the current grant holder
  always_comb begin
    ownerIdx = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) ownerIdx = IDX_W'(i);
  end

  // rotating pick: search upward from the holder, holder itself last
  always_comb begin
    logic found;
    found   = 1'b0;
    nextGnt = PARK_MASK;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(ownerIdx) + k) % N;
      if (!found && eligible[j]) begin
        found   = 1'b1;
        nextGnt = N'(1) << j;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gnt <= PARK_MASK;
    else if (strobe.rearb)
      gnt <= nextGnt;
  end

  for (genvar g = 0; g < N; g++) begin : gLock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lockedOut[g] <= 1'b0;
      else if (strobe.lockOwner && gnt[g])
        lockedOut[g] <= 1'b1;
      else if (!req[g])
        lockedOut[g] <= 1'b0;
    end
  end

  // R2: exactly one grant
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rstN)
    $countones(gnt) == 1);

  // R3: nobody eligible at a re-arbitration means the grant parks
  a_r3_park: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rearb && eligible == '0) |=> gnt == PARK_MASK);

  // R7: a timed-out holder loses the grant
  a_r7_drop_grant: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockOwner |=> (gnt & $past(gnt) & ~PARK_MASK) == '0);

  // R8: a locked master is never granted (except as the idle park agent)
  a_r8_locked_not_granted: assert property (@(posedge clk) disable iff (!rstN)
    (gnt & lockedOut & ~PARK_MASK) == '0);

  // R8: dropping the request releases the lockout at the next edge
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    (lockedOut & ~req) != '0 |=> (lockedOut & $past(lockedOut & ~req)) == '0);
endmodule

// File: rtl/lockout_arbiter.sv
module lockout_arbiter
  import lockArbPkg::*;
#(
  parameter int N     = 4,
  parameter int PARK  = 0,
  parameter int LIMIT = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lockoutOff,
  input  logic         frameN,
  input  logic         irdyN,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic [N-1:0] lockedOut
);
  arbStrobeT strobe;
  logic      ownerReq;

  arbControl #(.LIMIT(LIMIT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lockEnable(~lockoutOff),
    .frameN    (frameN),
    .irdyN     (irdyN),
    .ownerReq  (ownerReq),
    .strobe    (strobe)
  );

  arbDatapath #(.N(N), .PARK(PARK)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .strobe   (strobe),
    .gnt      (gnt),
    .lockedOut(lockedOut),
    .ownerReq (ownerReq)
  );
endmodule

// File: tb/lockout_arbiter_bench.sv
module lockout_arbiter_bench;
  localparam int PERIOD = 10;

  typedef struct {
    logic [3:0] g;
    logic [3:0] l;
    string      tag;
  } expT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lockoutOff = 1'b0;
  logic       frameN = 1'b1;
  logic       irdyN = 1'b1;
  logic [3:0] req = '0;
  logic [3:0] gnt;
  logic [3:0] lockedOut;

  int checks = 0;
  int errors = 0;
  expT q[$];

  lockout_arbiter u_lockout_arbiter (
    .clk(clk), .rstN(rstN), .lockoutOff(lockoutOff),
    .frameN(frameN), .irdyN(irdyN), .req(req),
    .gnt(gnt), .lockedOut(lockedOut)
  );

  always #(PERIOD/2) clk = ~clk;

  // driver: set inputs at the falling edge, queue what the next rising edge yields
  task automatic step(input logic [3:0] r, input logic fN, input logic iN,
                      input logic [3:0] eg, input logic [3:0] el, input string tag);
    expT e;
    @(negedge clk);
    req = r; frameN = fN; irdyN = iN;
    e.g = eg; e.l = el; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      while (q.size() > 0) begin
        expT e;
        e = q.pop_front();
        checks++;
        if (gnt !== e.g) begin
          errors++;
          $display("FAIL %s: gnt actual=%b expected=%b", e.tag, gnt, e.g);
        end
        checks++;
        if (lockedOut !== e.l) begin
          errors++;
          $display("FAIL %s: lockedOut actual=%b expected=%b", e.tag, lockedOut, e.l);
        end
        checks++;
        if ($countones(gnt) != 1) begin
          errors++;
          $display("FAIL R2: grant bits actual=%0d expected=1", $countones(gnt));
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1: reset state, checked while in reset
    #(PERIOD * 2 + 1);
    checks++;
    if (gnt !== 4'b0001 || lockedOut !== 4'b0000) begin
      errors++;
      $display("FAIL R1: in reset gnt/lock actual=%b/%b expected=0001/0000", gnt, lockedOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    step(4'b0000, 1, 1, 4'b0001, 4'b0000, "R1 after reset");

    // R3 grant, R4 rotation on start
    step(4'b0100, 1, 1, 4'b0100, 4'b0000, "R3 sole requester");
    step(4'b0110, 0, 1, 4'b0010, 4'b0000, "R4 start passes grant onward");
    step(4'b0010, 0, 0, 4'b0010, 4'b0000, "R4 hold during busy bus");
    step(4'b0010, 1, 0, 4'b0010, 4'b0000, "R4 hold last data phase");
    step(4'b0011, 0, 1, 4'b0001, 4'b0000, "R4 wrap to master 0");
    step(4'b1001, 1, 1, 4'b0001, 4'b0000, "R4 holder keeps without start");
    // R5 request drop
    step(4'b1000, 1, 1, 4'b1000, 4'b0000, "R5 holder drops request");
    step(4'b0000, 1, 1, 4'b0001, 4'b0000, "R3 park when idle");

    // R7 watchdog at the 16th idle edge
    step(4'b0100, 1, 1, 4'b0100, 4'b0000, "R7 grant");
    for (int k = 0; k < 15; k++)
      step(4'b0100, 1, 1, 4'b0100, 4'b0000, "R7 still granted");
    step(4'b0100, 1, 1, 4'b0001, 4'b0100, "R7 timeout");
    // R8 ignored while locked, release on drop
    for (int k = 0; k < 3; k++)
      step(4'b0100, 1, 1, 4'b0001, 4'b0100, "R8 locked request ignored");
    step(4'b0000, 1, 1, 4'b0001, 4'b0000, "R8 released");
    step(4'b0100, 1, 1, 4'b0100, 4'b0000, "R8 eligible again");

    // R6 busy edge restarts the count
    for (int k = 0; k < 10; k++)
      step(4'b0100, 1, 1, 4'b0100, 4'b0000, "R6 idle before busy");
    step(4'b0100, 1, 0, 4'b0100, 4'b0000, "R6 IRDY alone makes bus busy");
    for (int k = 0; k < 15; k++)
      step(4'b0100, 1, 1, 4'b0100, 4'b0000, "R6 count restarted");
    step(4'b0100, 1, 1, 4'b0001, 4'b0100, "R6 timeout after restart");
    step(4'b0000, 1, 1, 4'b0001, 4'b0000, "R8 released after R6");

    // R7 boundary: FRAME on the 16th edge is in time
    step(4'b0010, 1, 1, 4'b0010, 4'b0000, "R7 boundary grant");
    for (int k = 0; k < 15; k++)
      step(4'b0010, 1, 1, 4'b0010, 4'b0000, "R7 boundary wait");
    step(4'b0010, 0, 1, 4'b0010, 4'b0000, "R7 start at 16th edge in time");
    step(4'b0000, 1, 1, 4'b0001, 4'b0000, "R3 park after boundary");

    // R9 watchdog disabled
    @(negedge clk);
    lockoutOff = 1'b1;
    step(4'b1000, 1, 1, 4'b1000, 4'b0000, "R9 grant");
    for (int k = 0; k < 40; k++)
      step(4'b1000, 1, 1, 4'b1000, 4'b0000, "R9 no lockout when disabled");
    step(4'b0000, 1, 1, 4'b0001, 4'b0000, "R9 released only by request drop");

    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule